// File: doc/BRIEF.md
# I2C Register Target with Row-Wrapping Write Pointer

This block is a serial-bus target that sits between a two-wire I2C bus and a byte-wide register bank. SCL and SDA are brought into the core clock domain through a synchronizer and a glitch filter. Start, repeated start and stop conditions are decoded from the filtered lines. The target answers to a 7-bit address whose upper four bits are fixed and whose lower three bits come from strap pins.

A write transaction carries a pointer byte followed by data bytes. The data bytes go out on a single-cycle write strobe. The pointer steps forward inside an 8-byte row and wraps back to the start of that row. A read transaction streams bytes from the current pointer, and that pointer steps linearly over the whole 256-byte space.

When a transaction that wrote at least one data byte ends with a stop, the block models a nonvolatile row commit. For a programmable number of clock cycles it refuses its own address, so a master can poll until the commit is done.

Top module: `i2c_row_target`

## Requirements
- R1: After reset the SDA pull-down (`sda_oe_o`) is off, no write strobe is issued and the target is not busy, so it acknowledges its address at once.
- R2: The address byte is sent MSB first with the R/W bit in bit 0 (0 = write, 1 = read) and the address `1010` followed by `strap_i[2:0]` in bits 7..1. On a mismatch the target acknowledges nothing, writes nothing and stays silent until the next start condition.
- R3: In a write transaction the byte after the address is the pointer. The target acknowledges the address, the pointer and every data byte by pulling SDA low during the ninth clock (low = ACK).
- R4: Each data byte is written at the pointer. The pointer then advances in its low three bits only, so writes starting at 0xBE land at 0xBE, 0xBF and 0xB8.
- R5: A commit starts only at a stop condition, and only if the transaction wrote at least one data byte. A transaction that carried only a pointer, or was not addressed to the target, starts no commit.
- R6: For COMMIT_CYCLES clock cycles after a commit starts, the target does not acknowledge even its own address. After that time it acknowledges again.
- R7: A read returns bytes MSB first, starting at the pointer. A pointer-only write followed by a repeated start sets the pointer for the read that follows.
- R8: The pointer advances by one after each transmitted byte, linearly modulo 256 (0xFF is followed by 0x00). The next read transaction starts where the last one stopped.
- R9: A master NACK after a read byte ends the transfer. The target keeps SDA released until the next start condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_i | input | 3 | Low three address bits from strap pins |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | When high, pull SDA low (open-drain drive) |
| rb_addr_o | output | 8 | Register bank byte address |
| rb_wr_en_o | output | 1 | One-cycle write strobe to the register bank |
| rb_wr_data_o | output | 8 | Byte to write |
| rb_rd_data_i | input | 8 | Byte read combinationally at `rb_addr_o` |

## Verification
Two functions share the last data byte of a row. The write strobe for address 0xBF and the wrap of the pointer back to 0xB8 take effect on the same clock edge. A mistake there would put the byte at the wrong place or carry the wrap into the row bits. The bench provokes this with a three-byte write starting at 0xBE and judges the result by where the bytes land in the bank. Commit expiry and address judgement also meet: a poll placed right after a stop must be refused, and a poll placed after COMMIT_CYCLES must be accepted.

// File: rtl/i2c_row_pkg.sv
package i2c_row_pkg;
  localparam logic [3:0] DEV_ID = 4'b1010;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR,
    S_ADDR_ACK,
    S_PTR,
    S_PTR_ACK,
    S_WDATA,
    S_WDATA_ACK,
    S_TX,
    S_TX_ACK,
    S_IGNORE
  } tgt_state_t;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int LINES       = 2,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] clean_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [SYNC_STAGES-1:0] sync_q;
    logic [FILT_LEN-1:0]    hist_q;
    logic                   clean_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        sync_q  <= '1;
        hist_q  <= '1;
        clean_q <= 1'b1;
      end else begin
        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i[g]};
        hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
        if (&hist_q)       clean_q <= 1'b1;
        else if (~|hist_q) clean_q <= 1'b0;
      end
    end

    assign clean_o[g] = clean_q;
  end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o,
  output logic sda_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q      <= 1'b1;
      sda_q      <= 1'b1;
      scl_rise_o <= 1'b0;
      scl_fall_o <= 1'b0;
      start_o    <= 1'b0;
      stop_o     <= 1'b0;
      sda_o      <= 1'b1;
    end else begin
      scl_q      <= scl_i;
      sda_q      <= sda_i;
      scl_rise_o <= scl_i & ~scl_q;
      scl_fall_o <= ~scl_i & scl_q;
      start_o    <= scl_i & scl_q & ~sda_i & sda_q;
      stop_o     <= scl_i & scl_q & sda_i & ~sda_q;
      sda_o      <= sda_i;
    end
  end

  AST_START_STOP_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(start_o && stop_o)); // R2
endmodule

// File: rtl/i2c_commit_timer.sv
module i2c_commit_timer #(
  parameter int COMMIT_CYCLES = 1200
) (
  input  logic clk,
  input  logic rst,
  input  logic commit_i,
  output logic busy_o
);
  localparam int CW = $clog2(COMMIT_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(COMMIT_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                 cnt_q <= '0;
    else if (commit_i)       cnt_q <= LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  AST_BUSY_FROM_COMMIT: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(commit_i)); // R5
endmodule

// File: rtl/i2c_target_engine.sv
module i2c_target_engine
  import i2c_row_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] strap_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       sda_i,
  input  logic       busy_i,
  input  logic [7:0] rb_rd_data_i,
  output logic       sda_oe_o,
  output logic [7:0] rb_addr_o,
  output logic       rb_wr_en_o,
  output logic [7:0] rb_wr_data_o,
  output logic       commit_o
);
  tgt_state_t state_q;
  logic [3:0] cnt_q;
  logic [7:0] shreg_q;
  logic [7:0] txsh_q;
  logic [7:0] ptr_q;
  logic       is_read_q;
  logic       dirty_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= S_IDLE;
      cnt_q        <= '0;
      shreg_q      <= '0;
      txsh_q       <= '0;
      ptr_q        <= '0;
      is_read_q    <= 1'b0;
      dirty_q      <= 1'b0;
      sda_oe_o     <= 1'b0;
      rb_addr_o    <= '0;
      rb_wr_en_o   <= 1'b0;
      rb_wr_data_o <= '0;
      commit_o     <= 1'b0;
    end else begin
      rb_wr_en_o <= 1'b0;
      commit_o   <= 1'b0;
      rb_addr_o  <= ptr_q;
      if (stop_i) begin
        state_q  <= S_IDLE;
        sda_oe_o <= 1'b0;
        commit_o <= dirty_q;
        dirty_q  <= 1'b0;
      end else if (start_i) begin
        state_q  <= S_ADDR;
        cnt_q    <= '0;
        sda_oe_o <= 1'b0;
      end else begin
        case (state_q)
          S_ADDR, S_PTR, S_WDATA: begin
            if (scl_rise_i && cnt_q != 4'd8) begin
              shreg_q <= {shreg_q[6:0], sda_i};
              cnt_q   <= cnt_q + 4'd1;
            end else if (scl_fall_i && cnt_q == 4'd8) begin
              cnt_q <= '0;
              if (state_q == S_ADDR) begin
                if (shreg_q[7:1] == {DEV_ID, strap_i} && !busy_i) begin
                  sda_oe_o  <= 1'b1;
                  is_read_q <= shreg_q[0];
                  state_q   <= S_ADDR_ACK;
                end else begin
                  state_q <= S_IGNORE;
                end
              end else if (state_q == S_PTR) begin
                ptr_q    <= shreg_q;
                sda_oe_o <= 1'b1;
                state_q  <= S_PTR_ACK;
              end else begin
                rb_wr_en_o   <= 1'b1;
                rb_wr_data_o <= shreg_q;
                ptr_q        <= {ptr_q[7:3], ptr_q[2:0] + 3'd1};
                dirty_q      <= 1'b1;
                sda_oe_o     <= 1'b1;
                state_q      <= S_WDATA_ACK;
              end
            end
          end
          S_ADDR_ACK: begin
            if (scl_fall_i) begin
              if (is_read_q) begin
                sda_oe_o <= ~rb_rd_data_i[7];
                txsh_q   <= {rb_rd_data_i[6:0], 1'b0};
                state_q  <= S_TX;
              end else begin
                sda_oe_o <= 1'b0;
                state_q  <= S_PTR;
              end
            end
          end
          S_PTR_ACK, S_WDATA_ACK: begin
            if (scl_fall_i) begin
              sda_oe_o <= 1'b0;
              state_q  <= S_WDATA;
            end
          end
          S_TX: begin
            if (scl_rise_i) begin
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall_i) begin
              if (cnt_q == 4'd8) begin
                sda_oe_o <= 1'b0;
                ptr_q    <= ptr_q + 8'd1;
                cnt_q    <= '0;
                state_q  <= S_TX_ACK;
              end else begin
                sda_oe_o <= ~txsh_q[7];
                txsh_q   <= {txsh_q[6:0], 1'b0};
              end
            end
          end
          S_TX_ACK: begin
            if (scl_rise_i && sda_i) begin
              state_q <= S_IGNORE;
            end else if (scl_fall_i) begin
              sda_oe_o <= ~rb_rd_data_i[7];
              txsh_q   <= {rb_rd_data_i[6:0], 1'b0};
              state_q  <= S_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_ROW_STAYS: assert property (@(posedge clk) disable iff (rst)
    rb_wr_en_o |-> (ptr_q[7:3] == rb_addr_o[7:3] && ptr_q[2:0] == rb_addr_o[2:0] + 3'd1)); // R4
  AST_WRITE_ONLY_FROM_DATA: assert property (@(posedge clk) disable iff (rst)
    rb_wr_en_o |-> $past(state_q == S_WDATA)); // R2
  AST_NACK_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_ADDR_ACK) |-> !busy_i); // R6
  AST_COMMIT_AT_STOP: assert property (@(posedge clk) disable iff (rst)
    commit_o |-> $past(stop_i)); // R5
  AST_IGNORE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_IGNORE) |-> !sda_oe_o); // R9
endmodule

// File: rtl/i2c_row_target.sv
module i2c_row_target #(
  parameter int COMMIT_CYCLES = 1200,
  parameter int SYNC_STAGES   = 2,
  parameter int FILT_LEN      = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] strap_i,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  output logic [7:0] rb_addr_o,
  output logic       rb_wr_en_o,
  output logic [7:0] rb_wr_data_o,
  input  logic [7:0] rb_rd_data_i
);
  logic [1:0] clean;
  logic scl_rise, scl_fall, start, stop, sda_lvl, busy, commit;

  i2c_line_filter #(
    .LINES(2), .SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)
  ) u_filter (
    .clk(clk), .rst(rst), .raw_i({sda_i, scl_i}), .clean_o(clean)
  );

  i2c_bus_events u_events (
    .clk(clk), .rst(rst), .scl_i(clean[0]), .sda_i(clean[1]),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop), .sda_o(sda_lvl)
  );

  i2c_commit_timer #(.COMMIT_CYCLES(COMMIT_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .commit_i(commit), .busy_o(busy)
  );

  i2c_target_engine u_engine (
    .clk(clk), .rst(rst), .strap_i(strap_i),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start), .stop_i(stop), .sda_i(sda_lvl), .busy_i(busy),
    .rb_rd_data_i(rb_rd_data_i), .sda_oe_o(sda_oe_o),
    .rb_addr_o(rb_addr_o), .rb_wr_en_o(rb_wr_en_o),
    .rb_wr_data_o(rb_wr_data_o), .commit_o(commit)
  );

  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rb_wr_en_o |=> !rb_wr_en_o); // R4
endmodule

// File: tb/i2c_row_target_tb.sv
module i2c_row_target_tb;
  localparam int COMMIT = 1200;
  localparam int Q = 10;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] AW = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] AR = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_oe, rb_wr_en;
  logic [7:0] rb_addr, rb_wr_data, rb_rd_data;
  logic sda_bus;
  logic [7:0] bank [256];
  logic [7:0] exp_mem [256];
  int checks = 0, errors = 0;
  int oe_cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;
  assign rb_rd_data = bank[rb_addr];

  always_ff @(posedge clk) begin
    if (rb_wr_en) bank[rb_addr] <= rb_wr_data;
    if (sda_oe) oe_cycles <= oe_cycles + 1;
  end

  i2c_row_target #(.COMMIT_CYCLES(COMMIT)) u_dut (
    .clk(clk), .rst(rst), .strap_i(STRAP), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .rb_addr_o(rb_addr), .rb_wr_en_o(rb_wr_en),
    .rb_wr_data_o(rb_wr_data), .rb_rd_data_i(rb_rd_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic qw(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; qw(); scl = 1'b1; qw(2); scl = 1'b0; qw();
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; qw(); scl = 1'b1; qw(); b = sda_bus; qw(); scl = 1'b0; qw();
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; qw(); scl = 1'b1; qw(); sda_m = 1'b0; qw(); scl = 1'b0; qw();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; qw(); scl = 1'b1; qw(); sda_m = 1'b1; qw(2);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(b);
    ack = ~b;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) bit_in(d[i]);
    bit_out(~give_ack);
  endtask

  task automatic poll(output logic ack);
    i2c_start(); send_byte(AW, ack); i2c_stop();
  endtask

  task automatic t_reset();
    logic ack;
    chk("R1 sda_oe after reset", sda_oe, 1'b0);
    chk("R1 write strobe after reset", rb_wr_en, 1'b0);
    poll(ack);
    chk("R1 address ACK when not busy", ack, 1'b1);
  endtask

  task automatic t_bad_addr();
    logic ack;
    int oe0;
    oe0 = oe_cycles;
    i2c_start();
    send_byte({4'b1010, 3'b011, 1'b0}, ack);
    chk("R2 wrong strap address NACK", ack, 1'b0);
    send_byte(8'h10, ack);
    send_byte(8'h77, ack);
    chk("R2 later bytes NACK", ack, 1'b0);
    i2c_stop();
    chk("R2 no SDA drive while ignoring", oe_cycles - oe0, 0);
    chk("R2 bank untouched", bank[8'h10], exp_mem[8'h10]);
    poll(ack);
    chk("R5 no commit after foreign transaction", ack, 1'b1);
  endtask

  task automatic t_write_busy();
    logic a0, a1, a2, a3;
    i2c_start();
    send_byte(AW, a0); send_byte(8'h20, a1);
    send_byte(8'h11, a2); send_byte(8'h22, a3);
    i2c_stop();
    exp_mem[8'h20] = 8'h11; exp_mem[8'h21] = 8'h22;
    chk("R3 acks on address/pointer/data", {a0, a1, a2, a3}, 4'b1111);
    chk("R4 byte at 0x20", bank[8'h20], exp_mem[8'h20]);
    chk("R4 byte at 0x21", bank[8'h21], exp_mem[8'h21]);
    poll(a0);
    chk("R6 NACK own address during commit", a0, 1'b0);
    repeat (COMMIT) @(negedge clk);
    poll(a0);
    chk("R6 ACK after commit time", a0, 1'b1);
  endtask

  task automatic t_wrap();
    logic a0, a1, a2, a3, a4;
    i2c_start();
    send_byte(AW, a0); send_byte(8'hBE, a1);
    send_byte(8'hA1, a2); send_byte(8'hA2, a3); send_byte(8'hA3, a4);
    i2c_stop();
    exp_mem[8'hBE] = 8'hA1; exp_mem[8'hBF] = 8'hA2; exp_mem[8'hB8] = 8'hA3;
    chk("R3 acks on wrapping write", {a0, a1, a2, a3, a4}, 5'b11111);
    chk("R4 row wrap 0xBE", bank[8'hBE], exp_mem[8'hBE]);
    chk("R4 row wrap 0xBF", bank[8'hBF], exp_mem[8'hBF]);
    chk("R4 row wrap lands at 0xB8", bank[8'hB8], exp_mem[8'hB8]);
    chk("R4 no carry into 0xC0", bank[8'hC0], exp_mem[8'hC0]);
    repeat (COMMIT) @(negedge clk);
  endtask

  task automatic t_ptr_only();
    logic a0, a1;
    i2c_start(); send_byte(AW, a0); send_byte(8'h40, a1); i2c_stop();
    poll(a0);
    chk("R5 pointer-only write starts no commit", a0, 1'b1);
  endtask

  task automatic read_at(input logic [7:0] ptr, input int n, input string tag);
    logic a;
    logic [7:0] d;
    i2c_start(); send_byte(AW, a); send_byte(ptr, a);
    i2c_start(); send_byte(AR, a);
    chk({tag, " read address ACK"}, a, 1'b1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      chk({tag, " read data"}, d, exp_mem[8'(ptr + i)]);
    end
    chk("R9 SDA released after master NACK", sda_oe, 1'b0);
    bit_out(1'b1);
    chk("R9 SDA stays released", sda_oe, 1'b0);
    i2c_stop();
  endtask

  task automatic t_read();
    read_at(8'h20, 2, "R7");
    read_at(8'h17, 2, "R8 across row");
  endtask

  task automatic t_current_read();
    logic a;
    logic [7:0] d;
    i2c_start(); send_byte(AR, a);
    recv_byte(1'b0, d);
    i2c_stop();
    chk("R8 current-address read continues at 0x19", d, exp_mem[8'h19]);
    read_at(8'hFF, 2, "R8 modulo 256");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      bank[i] = 8'(i) ^ 8'h5A;
      exp_mem[i] = 8'(i) ^ 8'h5A;
    end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    t_bad_addr();
    t_write_busy();
    t_wrap();
    t_ptr_only();
    t_read();
    t_current_read();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule